// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block sits between a host register bus and the framer of a frame-based serial audio link. It runs register reads and writes in an external codec. Software first takes ownership of the link. It does this by reading a lock register: the read returns the old lock bit and leaves the bit set, so a returned zero means the caller now owns the link. Bus accesses to the upper half of the address space form a window onto the codec's 7-bit register space. A write in that window sends one write command to the framer.

A codec read takes two bus reads. The first returns whatever the capture register holds and starts a read command on the link. The codec's reply is accepted only when it carries the index that was requested. The reply is stored in the capture register and raises a read-done flag. A later read of the window returns the stored value and starts a new link read. If no matching reply arrives within a fixed number of frame-sync pulses, the capture register is loaded with an all-ones timeout value instead. Only one command is ever in flight. A window access that arrives while a command is pending is stalled on the bus until the pending command ends. Accesses to the lock and status registers are never stalled.

Top module: `codec_reg_seq`

## Requirements
- R1: A bus read of the lock register (word address 0x00) returns the lock bit in bit 0 with all other bits zero, and leaves the lock bit set afterwards.
- R2: A bus write to the lock register with bit 0 equal to 0 clears the lock bit. A write with bit 0 equal to 1 leaves the lock bit unchanged.
- R3: A write to a window address (bit 7 of the address set) issues one `cmd_valid` pulse in the cycle after the access is accepted, with `cmd_rd`=0, `cmd_addr` equal to address bits 6:0, and `cmd_data` equal to write data bits 15:0.
- R4: A pending write completes on the first `frame_sync` pulse seen while it is pending, including the cycle in which `cmd_valid` is shown. Completion sets the write-done flag (status register at word address 0x01, bit 0) and clears the lock bit.
- R5: A read of a window address returns the capture register zero-extended to 32 bits. It also issues one `cmd_valid` pulse with `cmd_rd`=1, `cmd_addr` equal to address bits 6:0, and `cmd_data`=0.
- R6: While a read is pending, a `rsp_valid` whose `rsp_addr` equals the pending index loads `rsp_data` into the capture register, sets the read-done flag (status bit 1) and clears the lock bit. A reply with any other index has no effect.
- R7: If a pending read sees 4 `frame_sync` pulses without a matching reply, it ends on the fourth pulse. The capture register becomes 0x0000FFFF, read-done is set and the lock bit is cleared. If a matching reply arrives in the same cycle as the fourth pulse, the reply wins.
- R8: Writing 1 to a status bit clears that bit, and writing 0 leaves it. When a set and a clear of the same bit fall in one cycle, the set wins. A status read returns {read-done, write-done} in bits 1:0.
- R9: While a command is pending, a window access is neither acknowledged nor issued until the cycle after the command ends. Lock and status accesses are served as usual during that time.
- R10: When a completion and a lock read fall in the same cycle, the read returns 0 and the lock bit ends up set.
- R11: After reset, the lock bit, both status flags and the capture register are zero, and `bus_ack` and `cmd_valid` are low.
- R12: Each accepted access gives one `bus_ack` pulse, one cycle long, in the cycle after acceptance. `bus_rdata` is valid in that cycle. Writes, and reads of unmapped register addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, held until `bus_ack` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| cmd_valid | output | 1 | One-cycle command to the framer |
| cmd_rd | output | 1 | Command is a read |
| cmd_addr | output | 7 | Codec register index |
| cmd_data | output | 16 | Codec write data |
| frame_sync | input | 1 | Pulse once per link frame |
| rsp_valid | input | 1 | Codec reply present |
| rsp_addr | input | 7 | Index carried by the reply |
| rsp_data | input | 16 | Data carried by the reply |

## Verification
Two pairs of events can fall in one cycle. The first pair is the completion of a link command and a bus access to the lock register. The bench provokes it by raising `frame_sync` in the same cycle that a lock read is presented while a write is pending. It then expects a returned zero and a lock bit that stays set. The second pair is a completion setting a status flag while software writes 1 to clear that flag. The bench drives a status clear together with the completing frame pulse, and expects the flag to read back as set. A behavioural model in the bench checks `bus_ack`, `bus_rdata` and every command field against these rules on every clock.

// File: rtl/cra_pkg.sv
package cra_pkg;
  // Register selected by a bus address
  typedef enum logic [1:0] {
    REG_LOCK = 2'd0,
    REG_STAT = 2'd1,
    REG_WIN  = 2'd2,
    REG_NONE = 2'd3
  } cra_reg_e;

  // Status register layout
  localparam int STAT_WDONE = 0;
  localparam int STAT_RDONE = 1;
  localparam int STAT_BITS  = 2;
endpackage

// File: rtl/cra_decode.sv
module cra_decode
  import cra_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 7,
  parameter int LOCK_OFS = 0,
  parameter int STAT_OFS = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output cra_reg_e          kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  // Top address bit opens the codec window; the low bits are the index
  always_comb begin
    if (addr[ADDR_W-1])     kind = REG_WIN;
    else if (addr == LOCK_A) kind = REG_LOCK;
    else if (addr == STAT_A) kind = REG_STAT;
    else                     kind = REG_NONE;
  end

  assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/cra_flags.sv
module cra_flags
  import cra_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lock_rd,
  input  logic                 lock_wr,
  input  logic                 lock_wbit,
  input  logic                 stat_wr,
  input  logic [STAT_BITS-1:0] stat_wbits,
  input  logic [STAT_BITS-1:0] stat_set,
  input  logic                 link_done,
  output logic                 lock_q,
  output logic                 lock_view,
  output logic [STAT_BITS-1:0] stat_q
);
  // Lock as seen this cycle: a finishing command frees the link at once
  assign lock_view = lock_q && !link_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (lock_rd) begin
      lock_q <= 1'b1;
    end else if (lock_wr && !lock_wbit) begin
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_view;
    end
  end

  // Sticky flags: write-one-to-clear, with the set taking priority
  for (genvar g = 0; g < STAT_BITS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[g] <= 1'b0;
      end else begin
        stat_q[g] <= (stat_q[g] && !(stat_wr && stat_wbits[g])) || stat_set[g];
      end
    end
  end
endmodule

// File: rtl/cra_link.sv
module cra_link #(
  parameter int IDX_W          = 7,
  parameter int CDATA_W        = 16,
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_wr,
  input  logic               issue_rd,
  input  logic [IDX_W-1:0]   issue_idx,
  input  logic [CDATA_W-1:0] issue_data,
  input  logic               frame_sync,
  input  logic               rsp_valid,
  input  logic [IDX_W-1:0]   rsp_addr,
  input  logic [CDATA_W-1:0] rsp_data,
  output logic               busy,
  output logic               wr_done,
  output logic               rd_done,
  output logic               tmo_hit,
  output logic [CDATA_W-1:0] cap_data,
  output logic               cmd_valid,
  output logic               cmd_rd,
  output logic [IDX_W-1:0]   cmd_addr,
  output logic [CDATA_W-1:0] cmd_data
);
  localparam int FW = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(TIMEOUT_FRAMES - 1);

  logic             is_rd;
  logic [IDX_W-1:0] idx_q;
  logic [FW-1:0]    frames;
  logic             match;

  // A reply counts only for the index that is outstanding
  assign match   = busy && is_rd && rsp_valid && (rsp_addr == idx_q);
  assign tmo_hit = busy && is_rd && !match && frame_sync && (frames == LAST_FRAME);
  assign wr_done = busy && !is_rd && frame_sync;
  assign rd_done = match || tmo_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      is_rd     <= 1'b0;
      idx_q     <= '0;
      frames    <= '0;
      cmd_valid <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= issue_wr || issue_rd;
      if (issue_wr || issue_rd) begin
        busy     <= 1'b1;
        is_rd    <= issue_rd;
        idx_q    <= issue_idx;
        frames   <= '0;
        cmd_rd   <= issue_rd;
        cmd_addr <= issue_idx;
        cmd_data <= issue_rd ? '0 : issue_data;
      end else if (wr_done || rd_done) begin
        busy <= 1'b0;
      end else if (busy && frame_sync) begin
        frames <= frames + 1'b1;
      end
    end
  end

  // Capture register: reply data, or the all-ones timeout value
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
    end else if (match) begin
      cap_data <= rsp_data;
    end else if (tmo_hit) begin
      cap_data <= '1;
    end
  end
endmodule

// File: rtl/codec_reg_seq.sv
module codec_reg_seq
  import cra_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int BUS_W          = 32,
  parameter int IDX_W          = 7,
  parameter int CDATA_W        = 16,
  parameter int TIMEOUT_FRAMES = 4,
  parameter int LOCK_OFS       = 0,
  parameter int STAT_OFS       = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic               bus_ack,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cmd_valid,
  output logic               cmd_rd,
  output logic [IDX_W-1:0]   cmd_addr,
  output logic [CDATA_W-1:0] cmd_data,
  input  logic               frame_sync,
  input  logic               rsp_valid,
  input  logic [IDX_W-1:0]   rsp_addr,
  input  logic [CDATA_W-1:0] rsp_data
);
  cra_reg_e             kind;
  logic [IDX_W-1:0]     idx;
  logic                 acc;
  logic                 lock_rd;
  logic                 lock_wr;
  logic                 stat_wr;
  logic                 win_wr;
  logic                 win_rd;
  logic                 busy;
  logic                 wr_done;
  logic                 rd_done;
  logic                 tmo_hit;
  logic [CDATA_W-1:0]   cap_data;
  logic                 lock_q;
  logic                 lock_view;
  logic [STAT_BITS-1:0] stat_q;
  logic [STAT_BITS-1:0] stat_set;
  logic [BUS_W-1:0]     rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_W-1:CDATA_W];

  cra_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .LOCK_OFS(LOCK_OFS),
    .STAT_OFS(STAT_OFS)
  ) u_dec (
    .addr(bus_addr),
    .kind(kind),
    .idx (idx)
  );

  // Register accesses always go through; window accesses wait for the link
  assign acc     = bus_sel && !bus_ack && ((kind != REG_WIN) || !busy);
  assign lock_rd = acc && !bus_wr && (kind == REG_LOCK);
  assign lock_wr = acc &&  bus_wr && (kind == REG_LOCK);
  assign stat_wr = acc &&  bus_wr && (kind == REG_STAT);
  assign win_wr  = acc &&  bus_wr && (kind == REG_WIN);
  assign win_rd  = acc && !bus_wr && (kind == REG_WIN);

  cra_link #(
    .IDX_W         (IDX_W),
    .CDATA_W       (CDATA_W),
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES)
  ) u_link (
    .clk       (clk),
    .rst       (rst),
    .issue_wr  (win_wr),
    .issue_rd  (win_rd),
    .issue_idx (idx),
    .issue_data(bus_wdata[CDATA_W-1:0]),
    .frame_sync(frame_sync),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data),
    .busy      (busy),
    .wr_done   (wr_done),
    .rd_done   (rd_done),
    .tmo_hit   (tmo_hit),
    .cap_data  (cap_data),
    .cmd_valid (cmd_valid),
    .cmd_rd    (cmd_rd),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  always_comb begin
    stat_set             = '0;
    stat_set[STAT_WDONE] = wr_done;
    stat_set[STAT_RDONE] = rd_done;
  end

  cra_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .lock_rd   (lock_rd),
    .lock_wr   (lock_wr),
    .lock_wbit (bus_wdata[0]),
    .stat_wr   (stat_wr),
    .stat_wbits(bus_wdata[STAT_BITS-1:0]),
    .stat_set  (stat_set),
    .link_done (wr_done || rd_done),
    .lock_q    (lock_q),
    .lock_view (lock_view),
    .stat_q    (stat_q)
  );

  // Read data selection; writes return zero
  always_comb begin
    rd_mux = '0;
    if (!bus_wr) begin
      unique case (kind)
        REG_LOCK: rd_mux[0]                 = lock_view;
        REG_STAT: rd_mux[STAT_BITS-1:0]     = stat_q;
        REG_WIN:  rd_mux[CDATA_W-1:0]       = cap_data;
        default:  rd_mux                    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= acc;
      if (acc) begin
        bus_rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/cra_checker.sv
module cra_checker #(
  parameter int CDATA_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_ack,
  input logic               cmd_valid,
  input logic               busy,
  input logic               wr_done,
  input logic               rd_done,
  input logic               tmo_hit,
  input logic               lock_rd,
  input logic               lock_q,
  input logic [1:0]         stat_q,
  input logic [CDATA_W-1:0] cap_data
);
  assert_ack_single_R12: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_no_issue_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_done && !rd_done) |=> !cmd_valid);

  assert_wdone_set_R4: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> stat_q[0]);

  assert_rdone_set_R6: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> stat_q[1]);

  assert_timeout_value_R7: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> (cap_data == {CDATA_W{1'b1}}));

  assert_lock_taken_R1: assert property (@(posedge clk) disable iff (rst)
    lock_rd |=> lock_q);

  assert_done_frees_R10: assert property (@(posedge clk) disable iff (rst)
    ((wr_done || rd_done) && !lock_rd) |=> !lock_q);
endmodule

bind codec_reg_seq cra_checker #(.CDATA_W(CDATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_ack  (bus_ack),
  .cmd_valid(cmd_valid),
  .busy     (busy),
  .wr_done  (wr_done),
  .rd_done  (rd_done),
  .tmo_hit  (tmo_hit),
  .lock_rd  (lock_rd),
  .lock_q   (lock_q),
  .stat_q   (stat_q),
  .cap_data (cap_data)
);

// File: tb/codec_reg_seq_tb.sv
module codec_reg_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        cmd_valid, cmd_rd;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic        frame_sync = 1'b0, rsp_valid = 1'b0;
  logic [6:0]  rsp_addr = '0;
  logic [15:0] rsp_data = '0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_reg_seq u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .frame_sync(frame_sync),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_lock, m_wd, m_rd, m_busy, m_isrd;
  int          m_frames;
  logic [6:0]  m_idx;
  logic [15:0] m_cap;
  bit          e_ack, e_cv, e_crd;
  logic [31:0] e_rdata;
  logic [6:0]  e_caddr;
  logic [15:0] e_cdata;
  string       e_tag = "R12";

  always @(posedge clk) begin
    if (rst) begin
      m_lock = 0; m_wd = 0; m_rd = 0; m_busy = 0; m_isrd = 0; m_frames = 0;
      m_idx = '0; m_cap = '0; e_ack = 0; e_cv = 0; e_crd = 0;
      e_rdata = '0; e_caddr = '0; e_cdata = '0;
    end else begin
      bit win, is_lock, is_stat, acc, cw, mt, to, done, lock_now;
      win     = bus_addr[7];
      is_lock = (bus_addr == 8'h00);
      is_stat = (bus_addr == 8'h01);
      cw   = m_busy && !m_isrd && frame_sync;
      mt   = m_busy && m_isrd && rsp_valid && (rsp_addr == m_idx);
      to   = m_busy && m_isrd && !mt && frame_sync && (m_frames == 3);
      done = cw || mt || to;
      lock_now = m_lock && !done;
      acc  = bus_sel && !e_ack && (!win || !m_busy);
      e_ack = acc;
      e_cv  = 0;
      if (mt) m_cap = rsp_data;
      else if (to) m_cap = 16'hFFFF;
      if (done) m_busy = 0;
      else if (m_busy && frame_sync) m_frames++;
      m_lock = lock_now;
      m_wd = m_wd || cw;
      m_rd = m_rd || mt || to;
      if (acc) begin
        e_rdata = '0;
        if (win) begin
          e_tag = bus_wr ? "R3" : "R5";
          if (!bus_wr) e_rdata = {16'h0, m_cap_prev(mt, to)};
          e_cv = 1; e_crd = !bus_wr; e_caddr = bus_addr[6:0];
          e_cdata = bus_wr ? bus_wdata[15:0] : 16'h0;
          m_busy = 1; m_isrd = !bus_wr; m_idx = bus_addr[6:0]; m_frames = 0;
        end else if (is_lock) begin
          e_tag = "R1";
          if (!bus_wr) begin e_rdata = {31'h0, lock_now}; m_lock = 1; end
          else if (!bus_wdata[0]) m_lock = 0;
        end else if (is_stat) begin
          e_tag = "R8";
          if (!bus_wr) e_rdata = {30'h0, m_rd_prev, m_wd_prev};
          else begin
            m_wd = (m_wd_prev && !bus_wdata[0]) || cw;
            m_rd = (m_rd_prev && !bus_wdata[1]) || mt || to;
          end
        end else begin
          e_tag = "R12";
        end
      end
      m_wd_prev = m_wd; m_rd_prev = m_rd; m_cap_hold = m_cap;
    end
  end

  // Flag and capture values as they stood before the current edge
  bit          m_wd_prev = 0, m_rd_prev = 0;
  logic [15:0] m_cap_hold = '0;
  function automatic logic [15:0] m_cap_prev(input bit a, input bit b);
    return m_cap_hold;
  endfunction

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R12 ack", {31'h0, bus_ack}, {31'h0, e_ack});
      if (e_ack) chk({e_tag, " rdata"}, bus_rdata, e_rdata);
      chk("R3/R5 cmd_valid", {31'h0, cmd_valid}, {31'h0, e_cv});
      if (e_cv) begin
        chk("R5 cmd_rd", {31'h0, cmd_rd}, {31'h0, e_crd});
        chk("R3 cmd_addr", {25'h0, cmd_addr}, {25'h0, e_caddr});
        chk("R3 cmd_data", {16'h0, cmd_data}, {16'h0, e_cdata});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic fs, output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; frame_sync = fs;
    @(negedge clk);
    frame_sync = 1'b0;
    while (!bus_ack) @(negedge clk);
    q = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic reply(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); rsp_valid = 1'b1; rsp_addr = a; rsp_data = d;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ack after reset", {31'h0, bus_ack}, 32'h0);
    chk("R11 cmd_valid after reset", {31'h0, cmd_valid}, 32'h0);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R11 status after reset", q, 32'h0);

    // lock acquire and software release
    bus_xfer(0, 8'h00, 0, 0, q); chk("R1 first lock read", q, 32'h0);
    bus_xfer(0, 8'h00, 0, 0, q); chk("R1 second lock read", q, 32'h1);
    bus_xfer(1, 8'h00, 32'h1, 0, q);
    bus_xfer(0, 8'h00, 0, 0, q); chk("R2 write one ignored", q, 32'h1);
    bus_xfer(1, 8'h00, 32'h0, 0, q);
    bus_xfer(0, 8'h00, 0, 0, q); chk("R2 write zero clears", q, 32'h0);

    // codec write
    bus_xfer(1, 8'h85, 32'h1234_ABCD, 0, q);
    frame_pulse();
    bus_xfer(0, 8'h01, 0, 0, q); chk("R4 write-done set", q, 32'h1);
    bus_xfer(0, 8'h00, 0, 0, q); chk("R4 lock freed", q, 32'h0);
    bus_xfer(1, 8'h01, 32'h1, 0, q);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R8 write-one clears", q, 32'h0);

    // two-pass codec read
    bus_xfer(0, 8'h92, 0, 0, q); chk("R5 first pass returns stale", q, 32'h0);
    reply(7'h13, 16'h5555);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R6 wrong index ignored", q, 32'h0);
    reply(7'h12, 16'hBEEF);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R6 read-done set", q, 32'h2);
    bus_xfer(0, 8'h92, 0, 0, q); chk("R6 second pass data", q, 32'h0000_BEEF);

    // timeout; register accesses served while pending
    bus_xfer(1, 8'h01, 32'h2, 0, q);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R9 status served while pending", q, 32'h0);
    repeat (4) frame_pulse();
    bus_xfer(0, 8'h01, 0, 0, q); chk("R7 read-done on timeout", q, 32'h2);
    bus_xfer(0, 8'h92, 0, 0, q); chk("R7 timeout value", q, 32'h0000_FFFF);
    reply(7'h12, 16'h0777);
    bus_xfer(0, 8'h90, 0, 0, q); chk("R6 captured reply", q, 32'h0000_0777);

    // window write stalled behind a pending read
    fork
      begin
        logic [31:0] q2;
        bus_xfer(1, 8'h81, 32'h0000_2222, 0, q2);
      end
      begin
        repeat (3) @(negedge clk);
        chk("R9 no ack while pending", {31'h0, bus_ack}, 32'h0);
        chk("R9 no command while pending", {31'h0, cmd_valid}, 32'h0);
        reply(7'h10, 16'h0333);
      end
    join

    // status clear coinciding with write completion
    bus_xfer(1, 8'h01, 32'h1, 1, q);
    bus_xfer(0, 8'h01, 0, 0, q); chk("R8 set wins over clear", q, 32'h3);
    bus_xfer(1, 8'h01, 32'h3, 0, q);

    // lock read coinciding with completion
    bus_xfer(0, 8'h00, 0, 0, q);
    bus_xfer(1, 8'h83, 32'h0000_4444, 0, q);
    bus_xfer(0, 8'h00, 0, 1, q); chk("R10 read sees freed link", q, 32'h0);
    bus_xfer(0, 8'h00, 0, 0, q); chk("R10 lock stays taken", q, 32'h1);
    bus_xfer(1, 8'h00, 32'h0, 0, q);
    bus_xfer(0, 8'h07, 0, 0, q); chk("R12 unmapped reads zero", q, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule